// File: doc/BRIEF.md
# DMA Transfer Queue Register Front End

This block is the software-facing control layer of a single-channel DMA engine. Software stages a transfer description in a set of parameter registers: source and destination address, strides, row length, row count and a repeat flag. It then submits the description to a four-entry submission queue. Each submitted transfer is tagged with a two-bit rotating ID. Software can read that ID before it submits, so it knows which tag the transfer will carry.

The queue offers its oldest entry to a transfer engine over a descriptor interface. The engine takes an entry with an accept strobe and later reports completion with a strobe and the finished ID. The block keeps the completions as a per-ID bitmask. It raises two interrupt causes, each maskable and cleared by writing one: one when the engine takes a queued entry and a slot frees up, and one when a transfer finishes. Clearing the run bit abandons all queued work.

Register access is a single-cycle write strobe with a combinational read path. Every register is 32 bits wide at a byte offset on an 8-bit address.

Top module: `dmaq_regs`

## Requirements
- R1: After reset the following read as zero: control, pending, done mask and next-ID. The interrupt mask reads 0x3, so both causes are masked. desc_valid and irq are low.
- R2: While the run bit (control bit 0) is set and the queue is not full, a write to SUBMIT (0x14) with bit 0 set queues the staged parameters tagged with the ID shown at NEXT_ID (0x10). NEXT_ID then advances by one modulo 4.
- R3: SUBMIT reads 1 while four transfers are queued and 0 otherwise. A submission while the queue is full is dropped and NEXT_ID stays unchanged.
- R4: desc_valid is high only when the queue holds an entry, the run bit is set and the hold bit (control bit 1) is clear. Entries are offered in submission order.
- R5: When eng_accept is high while desc_valid is high, the head entry is removed and pending bit 0 is set. ACTIVE (0x38) then shows the taken ID in bits 1:0, with bit 31 set as the busy flag.
- R6: eng_done sets bit eng_done_id of DONE (0x34) and sets pending bit 1. It clears the busy flag of ACTIVE when the ID matches the active ID.
- R7: Submitting a transfer clears the DONE bit of the ID it is given.
- R8: A write to PENDING (0x08) clears the pending bits that are set in the write data and leaves the others unchanged. An event arriving in the same cycle as a clear keeps its bit set.
- R9: irq is high exactly when a pending bit is set whose mask bit in MASK (0x04) is 0. SOURCE (0x0C) reads those unmasked pending bits.
- R10: Writing control with bit 0 clear empties the queue, so desc_valid is low afterwards, even once the run bit is set again. Submissions made while the run bit is clear are dropped.
- R11: MODE (0x18) bit 0 is stored with each queued entry and driven on desc_cyclic. The parameter registers SRC_ADDR (0x1C), DST_ADDR (0x20), X_LEN (0x24), Y_LEN (0x28), SRC_STRIDE (0x2C) and DST_STRIDE (0x30) read back as written and travel with the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| eng_enable | output | 1 | Run bit toward the engine |
| desc_valid | output | 1 | Head entry offered to the engine |
| desc_src | output | 32 | Source address of head entry |
| desc_dst | output | 32 | Destination address of head entry |
| desc_xlen | output | 32 | Row length field of head entry |
| desc_ylen | output | 32 | Row count field of head entry |
| desc_sstride | output | 32 | Source stride of head entry |
| desc_dstride | output | 32 | Destination stride of head entry |
| desc_cyclic | output | 1 | Repeat flag of head entry |
| desc_id | output | 2 | Transfer ID of head entry |
| eng_accept | input | 1 | Engine takes the head entry |
| eng_done | input | 1 | Engine reports a finished transfer |
| eng_done_id | input | 2 | ID of the finished transfer |

## Verification
The bench uses the default package values: a two-bit ID, a four-entry queue and 32-bit registers. With these values, four submissions are enough to fill the queue, push the rotating ID through its wrap back to zero, and attempt a fifth, refused submission. Because the queue depth equals the ID range, a freed slot allows an ID to be reissued while its old done bit is still set. This makes the clear-on-reissue rule and the race between a pending-bit clear and a simultaneous completion reachable in a short directed sequence.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  parameter int unsigned DW    = 32;
  parameter int unsigned AW    = 8;
  parameter int unsigned ID_W  = 2;
  localparam int unsigned TID_N = 1 << ID_W;
  localparam int unsigned NCAUSE = 2;

  localparam logic [AW-1:0] OFS_CTRL   = 8'h00;
  localparam logic [AW-1:0] OFS_IMASK  = 8'h04;
  localparam logic [AW-1:0] OFS_IPEND  = 8'h08;
  localparam logic [AW-1:0] OFS_ISRC   = 8'h0C;
  localparam logic [AW-1:0] OFS_NEXTID = 8'h10;
  localparam logic [AW-1:0] OFS_SUBMIT = 8'h14;
  localparam logic [AW-1:0] OFS_MODE   = 8'h18;
  localparam logic [AW-1:0] OFS_SRC    = 8'h1C;
  localparam logic [AW-1:0] OFS_DST    = 8'h20;
  localparam logic [AW-1:0] OFS_XLEN   = 8'h24;
  localparam logic [AW-1:0] OFS_YLEN   = 8'h28;
  localparam logic [AW-1:0] OFS_SSTR   = 8'h2C;
  localparam logic [AW-1:0] OFS_DSTR   = 8'h30;
  localparam logic [AW-1:0] OFS_DONE   = 8'h34;
  localparam logic [AW-1:0] OFS_ACTIVE = 8'h38;

  typedef struct packed {
    logic [DW-1:0]   src;
    logic [DW-1:0]   dst;
    logic [DW-1:0]   xlen;
    logic [DW-1:0]   ylen;
    logic [DW-1:0]   sstride;
    logic [DW-1:0]   dstride;
    logic            cyclic;
    logic [ID_W-1:0] id;
  } dmaq_desc_t;

  // Rotating tag for the next submission.
  function automatic logic [ID_W-1:0] tid_advance(input logic [ID_W-1:0] cur);
    return cur + 1'b1;
  endfunction

  // Completion mask update: reissue clears a bit, completion sets one (set wins).
  function automatic logic [TID_N-1:0] done_update(
      input logic [TID_N-1:0] cur,
      input logic             set_en,
      input logic [ID_W-1:0]  set_id,
      input logic             clr_en,
      input logic [ID_W-1:0]  clr_id);
    logic [TID_N-1:0] nxt;
    nxt = cur;
    if (clr_en) nxt[clr_id] = 1'b0;
    if (set_en) nxt[set_id] = 1'b1;
    return nxt;
  endfunction

  // Write-one-to-clear with event priority.
  function automatic logic [NCAUSE-1:0] pend_update(
      input logic [NCAUSE-1:0] cur,
      input logic              clr_en,
      input logic [NCAUSE-1:0] clr_bits,
      input logic [NCAUSE-1:0] evt);
    return ((clr_en ? (cur & ~clr_bits) : cur) | evt);
  endfunction
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo
  import dmaq_pkg::*;
#(
  parameter int unsigned DEPTH = TID_N
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  dmaq_desc_t                   push_d,
  input  logic                         pop,
  output dmaq_desc_t                   head,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  dmaq_desc_t        slot [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign count = cnt;
  assign head  = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) slot[g] <= '0;
        else if (push && !flush && wr_ptr == PW'(g)) slot[g] <= push_d;
      end
    end
  endgenerate
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq
  import dmaq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [NCAUSE-1:0] mask_wd,
  input  logic              pend_we,
  input  logic [NCAUSE-1:0] pend_wd,
  input  logic [NCAUSE-1:0] evt,
  output logic [NCAUSE-1:0] mask,
  output logic [NCAUSE-1:0] pend,
  output logic [NCAUSE-1:0] src,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
      pend <= '0;
    end else begin
      if (mask_we) mask <= mask_wd;
      pend <= pend_update(pend, pend_we, pend_wd, evt);
    end
  end

  assign src = pend & ~mask;
  assign irq = |src;
endmodule

// File: rtl/dmaq_regs.sv
module dmaq_regs
  import dmaq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq,
  output logic            eng_enable,
  output logic            desc_valid,
  output logic [DW-1:0]   desc_src,
  output logic [DW-1:0]   desc_dst,
  output logic [DW-1:0]   desc_xlen,
  output logic [DW-1:0]   desc_ylen,
  output logic [DW-1:0]   desc_sstride,
  output logic [DW-1:0]   desc_dstride,
  output logic            desc_cyclic,
  output logic [ID_W-1:0] desc_id,
  input  logic            eng_accept,
  input  logic            eng_done,
  input  logic [ID_W-1:0] eng_done_id
);
  localparam int unsigned CW = $clog2(TID_N+1);

  logic            run_q, hold_q, cyc_q;
  logic [DW-1:0]   src_q, dst_q, xlen_q, ylen_q, sstr_q, dstr_q;
  logic [ID_W-1:0] nid_q, act_id_q;
  logic            act_busy_q;
  logic [TID_N-1:0] done_q;

  // Named internal events.
  logic wr_ctrl, sub_req, sub_fire, flush_evt, pop_fire, cmp_fire;
  logic q_empty, q_full;
  logic [CW-1:0] q_count;
  dmaq_desc_t stage_d, head_d;
  logic [NCAUSE-1:0] imask, ipend, isrc;

  assign wr_ctrl   = reg_we && (reg_addr == OFS_CTRL);
  assign sub_req   = reg_we && (reg_addr == OFS_SUBMIT) && reg_wdata[0];
  assign sub_fire  = sub_req && run_q && !q_full;
  assign flush_evt = wr_ctrl && !reg_wdata[0];
  assign pop_fire  = eng_accept && desc_valid;
  assign cmp_fire  = eng_done;

  always_comb begin
    stage_d.src     = src_q;
    stage_d.dst     = dst_q;
    stage_d.xlen    = xlen_q;
    stage_d.ylen    = ylen_q;
    stage_d.sstride = sstr_q;
    stage_d.dstride = dstr_q;
    stage_d.cyclic  = cyc_q;
    stage_d.id      = nid_q;
  end

  dmaq_fifo #(.DEPTH(TID_N)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_evt),
    .push(sub_fire), .push_d(stage_d), .pop(pop_fire),
    .head(head_d), .empty(q_empty), .full(q_full), .count(q_count)
  );

  dmaq_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .mask_we(reg_we && (reg_addr == OFS_IMASK)), .mask_wd(reg_wdata[NCAUSE-1:0]),
    .pend_we(reg_we && (reg_addr == OFS_IPEND)), .pend_wd(reg_wdata[NCAUSE-1:0]),
    .evt({cmp_fire, pop_fire}),
    .mask(imask), .pend(ipend), .src(isrc), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; hold_q <= 1'b0; cyc_q <= 1'b0;
      src_q <= '0; dst_q <= '0; xlen_q <= '0; ylen_q <= '0;
      sstr_q <= '0; dstr_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_CTRL: begin run_q <= reg_wdata[0]; hold_q <= reg_wdata[1]; end
        OFS_MODE: cyc_q  <= reg_wdata[0];
        OFS_SRC:  src_q  <= reg_wdata;
        OFS_DST:  dst_q  <= reg_wdata;
        OFS_XLEN: xlen_q <= reg_wdata;
        OFS_YLEN: ylen_q <= reg_wdata;
        OFS_SSTR: sstr_q <= reg_wdata;
        OFS_DSTR: dstr_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nid_q      <= '0;
      done_q     <= '0;
      act_id_q   <= '0;
      act_busy_q <= 1'b0;
    end else begin
      if (sub_fire) nid_q <= tid_advance(nid_q);
      done_q <= done_update(done_q, cmp_fire, eng_done_id, sub_fire, nid_q);
      if (pop_fire) begin
        act_id_q   <= head_d.id;
        act_busy_q <= 1'b1;
      end else if (cmp_fire && eng_done_id == act_id_q) begin
        act_busy_q <= 1'b0;
      end
    end
  end

  assign eng_enable   = run_q;
  assign desc_valid   = run_q && !hold_q && !q_empty;
  assign desc_src     = head_d.src;
  assign desc_dst     = head_d.dst;
  assign desc_xlen    = head_d.xlen;
  assign desc_ylen    = head_d.ylen;
  assign desc_sstride = head_d.sstride;
  assign desc_dstride = head_d.dstride;
  assign desc_cyclic  = head_d.cyclic;
  assign desc_id      = head_d.id;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL:   reg_rdata = DW'({hold_q, run_q});
      OFS_IMASK:  reg_rdata = DW'(imask);
      OFS_IPEND:  reg_rdata = DW'(ipend);
      OFS_ISRC:   reg_rdata = DW'(isrc);
      OFS_NEXTID: reg_rdata = DW'(nid_q);
      OFS_SUBMIT: reg_rdata = DW'(q_full);
      OFS_MODE:   reg_rdata = DW'(cyc_q);
      OFS_SRC:    reg_rdata = src_q;
      OFS_DST:    reg_rdata = dst_q;
      OFS_XLEN:   reg_rdata = xlen_q;
      OFS_YLEN:   reg_rdata = ylen_q;
      OFS_SSTR:   reg_rdata = sstr_q;
      OFS_DSTR:   reg_rdata = dstr_q;
      OFS_DONE:   reg_rdata = DW'(done_q);
      OFS_ACTIVE: begin
        reg_rdata = DW'(act_id_q);
        reg_rdata[DW-1] = act_busy_q;
      end
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmaq_chk.sv
module dmaq_chk
  import dmaq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sub_fire,
  input logic             flush_evt,
  input logic             pop_fire,
  input logic             q_full,
  input logic             run_q,
  input logic             hold_q,
  input logic             desc_valid,
  input logic [ID_W-1:0]  nid_q,
  input logic [NCAUSE-1:0] ipend,
  input logic [TID_N-1:0] done_q,
  input logic             eng_done,
  input logic [ID_W-1:0]  eng_done_id
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !sub_fire) else $error("overflow"); // R3
  AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sub_fire |=> nid_q == ID_W'($past(nid_q) + 1'b1)) else $error("id step"); // R2
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_fire |=> $stable(nid_q)) else $error("id hold"); // R3
  AST_OFFER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (run_q && !hold_q)) else $error("offer gate"); // R4
  AST_SOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> ipend[0]) else $error("sot"); // R5
  AST_EOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> ipend[1]) else $error("eot"); // R6
  AST_DONE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> done_q[$past(eng_done_id)]) else $error("done mark"); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> !desc_valid) else $error("flush"); // R10
endmodule

bind dmaq_regs dmaq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sub_fire(sub_fire), .flush_evt(flush_evt),
  .pop_fire(pop_fire), .q_full(q_full), .run_q(run_q), .hold_q(hold_q),
  .desc_valid(desc_valid), .nid_q(nid_q), .ipend(ipend), .done_q(done_q),
  .eng_done(eng_done), .eng_done_id(eng_done_id)
);

// File: tb/tb_dmaq_regs.sv
module tb_dmaq_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;
  // {req[47:44], kind[43:40] (0 read-compare, 1 write), addr[39:32], data[31:0]}
  localparam logic [47:0] VEC [NV] = '{
    {4'd1,  4'd0, 8'h10, 32'h0},     // R1 next ID
    {4'd1,  4'd0, 8'h04, 32'h3},     // R1 mask
    {4'd1,  4'd0, 8'h00, 32'h0},     // R1 control
    {4'd1,  4'd0, 8'h34, 32'h0},     // R1 done
    {4'd10, 4'd1, 8'h14, 32'h1},     // R10 submit while stopped
    {4'd10, 4'd0, 8'h10, 32'h0},     // R10 dropped
    {4'd2,  4'd1, 8'h00, 32'h1},     // run
    {4'd11, 4'd1, 8'h1C, 32'h1000},  // R11
    {4'd11, 4'd1, 8'h24, 32'h3F},    // R11
    {4'd11, 4'd1, 8'h18, 32'h1},     // R11 cyclic
    {4'd2,  4'd1, 8'h14, 32'h1},     // R2 id 0
    {4'd2,  4'd0, 8'h10, 32'h1},     // R2
    {4'd2,  4'd1, 8'h14, 32'h1},     // id 1
    {4'd2,  4'd1, 8'h14, 32'h1},     // id 2
    {4'd3,  4'd0, 8'h14, 32'h0},     // R3 not full at 3
    {4'd2,  4'd1, 8'h14, 32'h1},     // id 3
    {4'd3,  4'd0, 8'h14, 32'h1},     // R3 full
    {4'd2,  4'd0, 8'h10, 32'h0},     // R2 wrap
    {4'd3,  4'd1, 8'h14, 32'h1},     // R3 refused
    {4'd3,  4'd0, 8'h10, 32'h0},     // R3 unchanged
    {4'd11, 4'd0, 8'h1C, 32'h1000}   // R11 readback
  };

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, eng_enable, desc_valid, desc_cyclic;
  logic [31:0] desc_src, desc_dst, desc_xlen, desc_ylen, desc_sstride, desc_dstride;
  logic [1:0] desc_id;
  logic eng_accept = 0, eng_done = 0;
  logic [1:0] eng_done_id = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaq_regs dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic accept();
    @(negedge clk); eng_accept = 1;
    @(negedge clk); eng_accept = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 desc_valid", {31'b0, desc_valid}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][43:40] == 4'd1) wr(VEC[i][39:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][39:32], v);
        chk($sformatf("R%0d vector %0d", VEC[i][47:44], i), v, VEC[i][31:0]);
      end
    end
    // R4 / R11: head is first submission
    chk("R4 desc_valid", {31'b0, desc_valid}, 1);
    chk("R4 head id", {30'b0, desc_id}, 0);
    chk("R11 desc_src", desc_src, 32'h1000);
    chk("R11 desc_cyclic", {31'b0, desc_cyclic}, 1);
    wr(8'h00, 32'h3);
    chk("R4 hold", {31'b0, desc_valid}, 0);
    wr(8'h00, 32'h1);
    // R5 accept
    accept();
    rd(8'h08, v); chk("R5 pending", v, 32'h1);
    rd(8'h38, v); chk("R5 active", v, 32'h8000_0000);
    chk("R4 order", {30'b0, desc_id}, 1);
    rd(8'h14, v); chk("R3 slot freed", v, 0);
    // R9 masking
    chk("R9 masked irq", {31'b0, irq}, 0);
    wr(8'h04, 32'h0);
    chk("R9 irq", {31'b0, irq}, 1);
    rd(8'h0C, v); chk("R9 source", v, 32'h1);
    // R8 W1C
    wr(8'h08, 32'h0);
    rd(8'h08, v); chk("R8 zero write", v, 32'h1);
    wr(8'h08, 32'h1);
    rd(8'h08, v); chk("R8 cleared", v, 0);
    chk("R9 irq low", {31'b0, irq}, 0);
    // R6 completion
    @(negedge clk); eng_done = 1; eng_done_id = 0;
    @(negedge clk); eng_done = 0;
    rd(8'h34, v); chk("R6 done", v, 32'h1);
    rd(8'h08, v); chk("R6 pending", v, 32'h2);
    rd(8'h38, v); chk("R6 busy cleared", v, 0);
    // R7 reissue of id 0
    wr(8'h14, 32'h1);
    rd(8'h34, v); chk("R7 done cleared", v, 0);
    // R8 clear racing a completion
    @(negedge clk); eng_done = 1; eng_done_id = 1;
    reg_we = 1; reg_addr = 8'h08; reg_wdata = 32'h2;
    @(negedge clk); eng_done = 0; reg_we = 0;
    rd(8'h08, v); chk("R8 event wins", v, 32'h2);
    rd(8'h34, v); chk("R6 done id1", v, 32'h2);
    // R10 flush
    wr(8'h00, 32'h0);
    chk("R10 flushed", {31'b0, desc_valid}, 0);
    wr(8'h00, 32'h1);
    chk("R10 stays empty", {31'b0, desc_valid}, 0);
    rd(8'h14, v); chk("R10 not full", v, 0);
    finish_run();
  end
endmodule